// File: doc/BRIEF.md
# Clock Controller Register File

This block is the software-visible register bank of a clock control unit. It sits on a simple word-addressed bus with a single-cycle write port and a read port that answers one cycle later. It holds nine 32-bit words: a mode word, two post-divider words, a main and a secondary PLL control word, three clock-gating words and a power-management word. A read of one fixed identification word returns a constant, and a read of any other unmapped word returns zero.

Each writable word has its own write mask. Bits outside the mask are stored as zero, and the mode word also has one bit that is always forced to one. Some writes change the inputs of the frequency arithmetic that lives elsewhere: writes to the mode, post-divider and PLL words. For these writes the block raises a one-cycle recalculation strobe. It gives the same strobe once when reset is released, so that the downstream arithmetic starts from the reset contents.

Top module: `clkctl_regbank`

## Requirements
- R1: Reset is synchronous and active low. While reset is held, the read data output is 0. After reset, the words read back their reset values: mode 0x074b0b7b, post-divider A 0xff870b48, post-divider B 0x49fcfe7f, each gating word 0xffffffff, power-management 0x80209828.
- R2: A word is selected by the byte address shifted right by 2, so address bits 1:0 are ignored. The word indices are: mode 0, post-divider A 1, post-divider B 2, main PLL 4, secondary PLL 6, gating words 8, 9 and 10, power-management 23.
- R3: A write to the mode word stores the data ANDed with 0x3b6fdfff, with bit 26 set to 1 in every case.
- R4: A write to post-divider A stores the data ANDed with 0xff9f3fff. Writes to either PLL word store the data ANDed with 0xbfff3fff. Post-divider B and the three gating words store all 32 bits.
- R5: A PLL word holds the pre-divider in bits 29:26, the denominator in 25:16, the integer multiplier in 13:10 and the numerator in 9:0. The main PLL resets to pre-divider 1, denominator 0, integer 6, numerator 0 (0x04001800). The secondary PLL resets to pre-divider 1, denominator 4, integer 12, numerator 1 (0x04043001).
- R6: A read of word 18 returns 0x00004040. A read of any other unmapped word returns 0. A write to word 18 or to an unmapped word changes no stored word.
- R7: The power-management word can be read, and writes to it have no effect.
- R8: The read data appears on the cycle after the read request. When no read is requested, the output keeps its last value.
- R9: The recalculation strobe is high for exactly the cycle after a write to word 0, 1, 2, 4 or 6. A write to a gating word, to the power-management word or to an unmapped word does not raise it.
- R10: The strobe is high for the single cycle that follows the first active clock edge after reset is released.
- R11: A read and a write to the same word in the same cycle return the value the word held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | Write request for this cycle |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_valid_i | input | 1 | Read request for this cycle |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | 32 | Registered read data, valid the cycle after a request |
| recalc_o | output | 1 | One-cycle strobe asking for the derived frequencies to be recomputed |

## Verification
Two situations are the hardest to bring about from the ports. The first is the strobe that follows reset release, because it happens exactly once and only on the first active edge. The second is a read that hits the same word as a write in the same cycle. The bench handles the first with a strobe model that runs from the very first edge after reset, which makes the single cycle after release a checked cycle. It handles the second by driving both ports with the same address in one cycle and expecting the old contents, followed by a read that must show the new contents. Addresses with nonzero low bits, the top word of the address space and writes to the constant word are also used, so that decoding faults show up.

// File: rtl/clkctl_pkg.sv
// Package: word indices, reset contents, write masks and forced bits for the
// clock controller register file. Assumes 32-bit words on a byte address bus.
package clkctl_pkg;

    localparam int DATA_W     = 32;
    localparam int NREG       = 9;
    localparam int CONST_WORD = 18;
    localparam logic [DATA_W-1:0] CONST_VAL = 32'h0000_4040;

    // Storage slot numbers (not bus word indices)
    localparam int SLOT_MODE  = 0;
    localparam int SLOT_PDA   = 1;
    localparam int SLOT_PDB   = 2;
    localparam int SLOT_MPLL  = 3;
    localparam int SLOT_SPLL  = 4;
    localparam int SLOT_GATE0 = 5;
    localparam int SLOT_PWR   = 8;

    // Pack PLL fields: pre-divider 29:26, denominator 25:16, integer 13:10, numerator 9:0
    function automatic logic [DATA_W-1:0] pll_pack(int unsigned pd, int unsigned den,
                                                   int unsigned mul, int unsigned num);
        logic [DATA_W-1:0] v;
        v        = '0;
        v[29:26] = 4'(pd);
        v[25:16] = 10'(den);
        v[13:10] = 4'(mul);
        v[9:0]   = 10'(num);
        return v;
    endfunction

    // Bus word index of each storage slot
    function automatic int unsigned slot_word(int i);
        case (i)
            SLOT_MODE: return 0;
            SLOT_PDA:  return 1;
            SLOT_PDB:  return 2;
            SLOT_MPLL: return 4;
            SLOT_SPLL: return 6;
            5:         return 8;
            6:         return 9;
            7:         return 10;
            default:   return 23;
        endcase
    endfunction

    // Reset contents of each slot
    function automatic logic [DATA_W-1:0] slot_rst(int i);
        case (i)
            SLOT_MODE: return 32'h074b_0b7b;
            SLOT_PDA:  return 32'hff87_0b48;
            SLOT_PDB:  return 32'h49fc_fe7f;
            SLOT_MPLL: return pll_pack(1, 0, 6, 0);
            SLOT_SPLL: return pll_pack(1, 4, 12, 1);
            5, 6, 7:   return 32'hffff_ffff;
            default:   return 32'h8020_9828;
        endcase
    endfunction

    // Bits kept from write data
    function automatic logic [DATA_W-1:0] slot_mask(int i);
        case (i)
            SLOT_MODE:            return 32'h3b6f_dfff;
            SLOT_PDA:             return 32'hff9f_3fff;
            SLOT_MPLL, SLOT_SPLL: return 32'hbfff_3fff;
            SLOT_PWR:             return 32'h0000_0000;
            default:              return 32'hffff_ffff;
        endcase
    endfunction

    // Bits set on every write
    function automatic logic [DATA_W-1:0] slot_force(int i);
        return (i == SLOT_MODE) ? (32'h1 << 26) : 32'h0;
    endfunction

    function automatic bit slot_writable(int i);
        return i != SLOT_PWR;
    endfunction

    // Slots whose writes request frequency recomputation
    function automatic logic [NREG-1:0] recalc_vec();
        logic [NREG-1:0] v;
        v = '0;
        for (int i = 0; i < NREG; i++) v[i] = (i < SLOT_GATE0);
        return v;
    endfunction

endpackage

// File: rtl/clkctl_cfg_reg.sv
// One configuration word: loads masked write data with forced bits, or stays
// read-only. Assumes the write enable is already decoded for this word.
module clkctl_cfg_reg #(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] RST_VAL  = '0,
    parameter logic [DATA_W-1:0] WMASK    = '1,
    parameter logic [DATA_W-1:0] FORCE    = '0,
    parameter bit                WRITABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    generate
        if (WRITABLE) begin : g_rw
            // Purpose: hold the word, load masked data plus forced bits on write
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= RST_VAL;
                else if (we)  q <= (wdata & WMASK) | FORCE;
            end

            assert_no_stray_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> ((q & ~(WMASK | FORCE)) == '0));
            assert_forced_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
                we |=> ((q & FORCE) == FORCE));
        end else begin : g_ro
            // Purpose: hold the reset contents; write data is never taken
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
            end

            assert_ro_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(q));
        end
    endgenerate

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/clkctl_decode.sv
// Address decoder: turns a byte address into a one-hot slot hit vector and a
// hit flag for the constant word. Assumes the word index is the address >> 2.
module clkctl_decode #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic [clkctl_pkg::NREG-1:0] hit,
    output logic                       const_hit
);
    import clkctl_pkg::*;

    logic [ADDR_W-1:0] word_idx;

    // Purpose: compare the word index against each slot and the constant word
    always_comb begin
        word_idx  = addr >> 2;
        const_hit = (word_idx == ADDR_W'(CONST_WORD));
        for (int i = 0; i < NREG; i++) begin
            hit[i] = (word_idx == ADDR_W'(slot_word(i)));
        end
    end

    always_comb begin
        assert_onehot_hit_R2: assert ($onehot0({hit, const_hit}));
    end

endmodule

// File: rtl/clkctl_rdmux.sv
// Read path: selects the addressed word, the constant or zero, and registers
// it. Assumes at most one hit is active. Output holds when no read is asked.
module clkctl_rdmux (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          rd_en,
    input  logic [clkctl_pkg::NREG-1:0]                   hit,
    input  logic                                          const_hit,
    input  logic [clkctl_pkg::NREG-1:0][clkctl_pkg::DATA_W-1:0] words,
    output logic [clkctl_pkg::DATA_W-1:0]                 rd_data
);
    import clkctl_pkg::*;

    logic [DATA_W-1:0] sel;

    // Purpose: OR-select the hit word; the constant word overrides
    always_comb begin
        sel = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) sel = sel | words[i];
        end
        if (const_hit) sel = CONST_VAL;
    end

    // Purpose: register read data one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    assert_const_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && const_hit |=> rd_data == CONST_VAL);
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !const_hit && (hit == '0) |=> rd_data == '0);
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/clkctl_strobe.sv
// Recalculation strobe: one cycle high after a qualifying write, and once
// after reset release. Assumes the write hit vector is already decoded.
module clkctl_strobe #(
    parameter logic [clkctl_pkg::NREG-1:0] QUAL = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [clkctl_pkg::NREG-1:0] wr_hit,
    output logic                       pulse
);

    logic boot_q;

    // Purpose: arm the post-reset pulse, clear it on the first active edge
    always_ff @(posedge clk) begin
        if (!rst_n) boot_q <= 1'b1;
        else        boot_q <= 1'b0;
    end

    // Purpose: raise the strobe for one cycle per qualifying event
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= boot_q | (wr_en & |(wr_hit & QUAL));
    end

    assert_boot_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_q |=> pulse);
    assert_boot_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_q |=> !boot_q);

endmodule

// File: rtl/clkctl_regbank.sv
// Top: clock controller register file. Decodes separate write and read
// addresses, holds nine words with per-word masks, serves a constant word and
// raises the recalculation strobe. Assumes one write and one read per cycle.
module clkctl_regbank #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_valid_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              recalc_o
);
    import clkctl_pkg::*;

    localparam logic [NREG-1:0] RECALC = recalc_vec();

    logic [NREG-1:0]             wr_hit;
    logic [NREG-1:0]             rd_hit;
    logic                        wr_const_hit;
    logic                        rd_const_hit;
    logic [NREG-1:0][DATA_W-1:0] words;

    clkctl_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
        .addr      (wr_addr_i),
        .hit       (wr_hit),
        .const_hit (wr_const_hit)
    );

    clkctl_decode #(.ADDR_W(ADDR_W)) u_rd_dec (
        .addr      (rd_addr_i),
        .hit       (rd_hit),
        .const_hit (rd_const_hit)
    );

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_slot
            clkctl_cfg_reg #(
                .DATA_W   (DATA_W),
                .RST_VAL  (slot_rst(i)),
                .WMASK    (slot_mask(i)),
                .FORCE    (slot_force(i)),
                .WRITABLE (slot_writable(i))
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_valid_i & wr_hit[i]),
                .wdata (wr_data_i),
                .q     (words[i])
            );
        end
    endgenerate

    clkctl_rdmux u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_valid_i),
        .hit       (rd_hit),
        .const_hit (rd_const_hit),
        .words     (words),
        .rd_data   (rd_data_o)
    );

    clkctl_strobe #(.QUAL(RECALC)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_valid_i),
        .wr_hit (wr_hit),
        .pulse  (recalc_o)
    );

    // The constant word has no storage, so a write there may only leave every slot alone
    assert_const_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i && wr_const_hit |=> $stable(words));
    assert_pulse_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i && |(wr_hit & RECALC) |=> recalc_o);
    assert_quiet_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i && ((wr_hit & RECALC) == '0) && $past(rst_n) |=> !recalc_o);

endmodule

// File: tb/clkctl_regbank_tb_top.sv
`timescale 1ns/1ps
module clkctl_regbank_tb_top;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              recalc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    item_t mon_it;

    logic rd_seen = 1'b0;
    logic exp_boot, exp_pulse, exp_was_boot;

    always #10 clk = ~clk;  // 50 MHz

    clkctl_regbank #(.ADDR_W(ADDR_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_valid_i (rd_valid),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .recalc_o   (recalc)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Writes to words 0,1,2,4,6 request recomputation (R9)
    function automatic bit qual_word(logic [ADDR_W-1:0] a);
        int unsigned w = int'(a >> 2);
        return (w == 0) || (w == 1) || (w == 2) || (w == 4) || (w == 6);
    endfunction

    // Strobe model from R9/R10
    always @(posedge clk) begin
        rd_seen      <= rd_valid;
        exp_boot     <= !rst_n;
        exp_was_boot <= rst_n && exp_boot;
        exp_pulse    <= !rst_n ? 1'b0 : (exp_boot | (wr_valid && qual_word(wr_addr)));
    end

    // Monitor: read scoreboard and per-cycle strobe comparison
    always @(negedge clk) begin
        if (rd_seen && !done) begin
            if (sb_q.size() == 0) begin
                check("R8 unexpected read response", 32'h1, 32'h0);
            end else begin
                mon_it = sb_q.pop_front();
                check(mon_it.tag, rd_data, mon_it.exp);
            end
        end
        if (rst_n && !done) begin
            check(exp_was_boot ? "R10 boot strobe" : "R9 strobe", {31'b0, recalc}, {31'b0, exp_pulse});
        end
    end

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic same_cycle(logic [ADDR_W-1:0] a, logic [31:0] d, logic [31:0] old);
        item_t it;
        @(negedge clk);
        it.exp = old; it.tag = "R11 read during write";
        sb_q.push_back(it);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;   // first active edge follows, strobe expected after it (R10)

        // R1 / R5 reset contents
        bus_read(12'h000, 32'h074b_0b7b, "R1 mode reset");
        bus_read(12'h004, 32'hff87_0b48, "R1 pdiv A reset");
        bus_read(12'h008, 32'h49fc_fe7f, "R1 pdiv B reset");
        bus_read(12'h010, 32'h0400_1800, "R5 main pll reset");
        bus_read(12'h018, 32'h0404_3001, "R5 secondary pll reset");
        bus_read(12'h020, 32'hffff_ffff, "R1 gate0 reset");
        bus_read(12'h024, 32'hffff_ffff, "R1 gate1 reset");
        bus_read(12'h028, 32'hffff_ffff, "R1 gate2 reset");
        bus_read(12'h05c, 32'h8020_9828, "R1 power reset");

        // R6 constant and unmapped reads
        bus_read(12'h048, 32'h0000_4040, "R6 constant word");
        bus_read(12'h00c, 32'h0, "R6 unmapped word 3");
        bus_read(12'hffc, 32'h0, "R6 unmapped top word");

        // R3 mode masking and forced bit
        bus_write(12'h000, 32'hffff_ffff);
        bus_read(12'h000, 32'h3f6f_dfff, "R3 mode all ones");
        bus_write(12'h000, 32'h0000_0000);
        bus_read(12'h000, 32'h0400_0000, "R3 mode zero keeps bit 26");

        // R4 masks
        bus_write(12'h004, 32'hffff_ffff);
        bus_read(12'h004, 32'hff9f_3fff, "R4 pdiv A mask");
        bus_write(12'h008, 32'hdead_beef);
        bus_read(12'h008, 32'hdead_beef, "R4 pdiv B full");
        bus_write(12'h010, 32'hffff_ffff);
        bus_read(12'h010, 32'hbfff_3fff, "R4 main pll mask");
        bus_write(12'h013, 32'h1234_5678);   // R2: low bits ignored, word 4
        bus_read(12'h011, 32'h1234_1678, "R2 R4 main pll via offset bytes");
        bus_write(12'h018, 32'h1234_5678);
        bus_read(12'h018, 32'h1234_1678, "R4 secondary pll mask");
        bus_write(12'h020, 32'ha5a5_a5a5);
        bus_write(12'h024, 32'h0000_0000);
        bus_write(12'h02a, 32'h1234_5678);
        bus_read(12'h020, 32'ha5a5_a5a5, "R4 gate0 full");
        bus_read(12'h024, 32'h0000_0000, "R4 gate1 full");
        bus_read(12'h028, 32'h1234_5678, "R2 R4 gate2 full");

        // R7 power word ignores writes
        bus_write(12'h05c, 32'h0000_0000);
        bus_read(12'h05c, 32'h8020_9828, "R7 power unchanged");

        // R6 writes to constant and unmapped words change nothing
        bus_write(12'h048, 32'hffff_ffff);
        bus_write(12'h00c, 32'hffff_ffff);
        bus_read(12'h048, 32'h0000_4040, "R6 constant after write");
        bus_read(12'h00c, 32'h0, "R6 unmapped after write");
        bus_read(12'h008, 32'hdead_beef, "R6 pdiv B untouched");
        bus_read(12'h014, 32'h0, "R6 unmapped word 5 after write");

        // R11 same-cycle read and write
        same_cycle(12'h008, 32'h0bad_f00d, 32'hdead_beef);
        bus_read(12'h008, 32'h0bad_f00d, "R11 new value visible");

        // R8 hold when no read
        bus_read(12'h024, 32'h0000_0000, "R8 setup");
        bus_read(12'h018, 32'h1234_1678, "R8 last read");
        repeat (3) @(negedge clk);
        check("R8 hold without read", rd_data, 32'h1234_1678);

        // Back-to-back qualifying write after idle, strobe model covers R9
        bus_write(12'h004, 32'h0000_0001);
        repeat (2) @(negedge clk);
        check("R8 all reads answered", 32'(sb_q.size()), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule